// File: doc/BRIEF.md
# Piecewise Quadratic Sine Interpolator

This block turns a phase word into a signed sine amplitude without a full waveform memory. The two most significant phase bits pick the quadrant. Quarter-wave symmetry folds every phase onto the first quarter of the cycle. Within that quarter, the upper bits of the folded index pick one of a small set of segments. Each segment holds three second-order coefficients, and these are fixed when the design is elaborated. The low bits form an offset x, and the block evaluates c0 + x·(c1 + x·c2) in Horner form.

A new phase may enter on every clock. Each result leaves exactly four clocks later, and its valid flag follows it through the pipeline. The default build uses a 12-bit phase. Its coefficient table has 16 segments of three entries each, which is 48 words in place of the 4096 samples that a direct table would need.

Top module: `sine_pp_interp`

## Requirements
- R1: A phase accepted with `in_valid` high at a rising edge gives `out_valid` high after exactly the fourth following rising edge. A clock with `in_valid` low gives `out_valid` low four edges later, and back-to-back inputs give back-to-back outputs.
- R2: For phase p, the output stays within ±2 LSB of round(32767·sin(2π·p/2^PHASE_W)), for every phase value.
- R3: The output is a 16-bit two's-complement value that never leaves the range −32767 to +32767. A result that rounds past either rail is clamped to that rail.
- R4: Phases whose top bit is 0 (first half-cycle) give outputs ≥ 0. Phases whose top bit is 1 give outputs ≤ 0.
- R5: The quarter-wave fold is exact. For 0 < q < 2^(PHASE_W−2), the outputs for the quarter phase plus q and the quarter phase minus q are identical. The output for p + half-cycle is the exact negation of the output for p.
- R6: While `rst_n` is low, `out_valid` is 0 and `out_sample` is 0.
- R7: `out_sample` keeps its last value on any cycle where `out_valid` is low.
- R8: The cardinal phases give exact values: phase 0 gives 0, the quarter phase gives +32767, the half phase gives 0, and the three-quarter phase gives −32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phase word present this cycle |
| in_phase | input | PHASE_W | Unsigned phase, full scale equal to one cycle |
| out_valid | output | 1 | Sample present, four clocks after its phase |
| out_sample | output | OUT_W | Signed two's-complement sine amplitude |

## Verification
A result leaves the last stage in the same cycle that a new phase enters the first. The hold rule for idle cycles also applies in the cycle right after a burst ends. The stimulus runs one unbroken sweep of every phase. It then runs a stretch in which `in_valid` follows a pseudo-random on/off pattern, so that bubbles and accepted phases interleave in every possible alignment. On every clock, a queue in the bench holding the phases sent four clocks earlier decides whether a sample is due. If one is due, it is scored against a real-valued sine. If none is due, the bench checks that the previous sample is unchanged.

// File: rtl/sine_pp_pkg.sv
package sine_pp_pkg;

  localparam real PP_TWO_PI = 6.283185307179586476925;

  // Sine by Taylor series; argument lies in [0, pi/2]
  function automatic real pp_sin(input real a);
    real term;
    real sum;
    term = a;
    sum  = a;
    for (int i = 1; i < 14; i++) begin
      term = -term * a * a / (real'(2 * i) * real'(2 * i + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // Quadratic through segment start, middle and end, scaled by 2^frac.
  // which: 0 -> constant, 1 -> linear, 2 -> square term (x counted in integer steps)
  function automatic longint pp_coef(input int seg, input int which, input int ob,
                                     input int sb, input int amp, input int frac);
    real n;
    real full;
    real base;
    real y0;
    real y1;
    real y2;
    real k0;
    real k1;
    real k2;
    real sc;
    n    = real'(longint'(1) << ob);
    full = real'(longint'(1) << (ob + sb + 2));
    base = real'(seg) * n;
    y0   = real'(amp) * pp_sin(PP_TWO_PI * base / full);
    y1   = real'(amp) * pp_sin(PP_TWO_PI * (base + n / 2.0) / full);
    y2   = real'(amp) * pp_sin(PP_TWO_PI * (base + n) / full);
    k2   = (y0 - 2.0 * y1 + y2) / (n * n / 2.0);
    k1   = (y2 - y0) / n - k2 * n;
    k0   = y0;
    sc   = 1.0;
    for (int i = 0; i < frac; i++) sc = sc * 2.0;
    case (which)
      0:       return longint'(k0 * sc);
      1:       return longint'(k1 * sc);
      default: return longint'(k2 * sc);
    endcase
  endfunction

endpackage

// File: rtl/sine_pp_fold.sv
module sine_pp_fold #(
  parameter int PHASE_W = 12,
  parameter int SEG_BITS = 4
) (
  input  logic [PHASE_W-1:0]              phase,
  output logic [SEG_BITS-1:0]             seg,
  output logic [PHASE_W-SEG_BITS-2:0]     xoff,
  output logic                            negate,
  output logic                            at_peak
);
  localparam int QW = PHASE_W - 2;
  localparam int OB = QW - SEG_BITS;
  localparam logic [QW:0] QUART = {1'b1, {QW{1'b0}}};

  logic [QW-1:0] q;
  logic          mirror;
  logic [QW:0]   m;

  assign q       = phase[QW-1:0];
  assign mirror  = phase[PHASE_W-2];
  assign negate  = phase[PHASE_W-1];
  // mirrored quarter index runs 1..QUART, so the quarter point itself is reachable
  assign m       = mirror ? (QUART - {1'b0, q}) : {1'b0, q};
  assign at_peak = m[QW];
  assign seg     = at_peak ? '1 : m[QW-1 -: SEG_BITS];
  assign xoff    = at_peak ? {1'b1, {OB{1'b0}}} : {1'b0, m[OB-1:0]};
endmodule

// File: rtl/sine_pp_coef_rom.sv
module sine_pp_coef_rom #(
  parameter int SEG_BITS = 4,
  parameter int OFF_BITS = 6,
  parameter int AMP = 32767,
  parameter int FRAC = 16,
  parameter int CW = 40
) (
  input  logic [SEG_BITS-1:0]   seg,
  output logic signed [CW-1:0]  c0,
  output logic signed [CW-1:0]  c1,
  output logic signed [CW-1:0]  c2
);
  localparam int NSEG = 1 << SEG_BITS;

  logic signed [CW-1:0] t0 [NSEG];
  logic signed [CW-1:0] t1 [NSEG];
  logic signed [CW-1:0] t2 [NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam logic signed [CW-1:0] K0 =
      CW'(sine_pp_pkg::pp_coef(k, 0, OFF_BITS, SEG_BITS, AMP, FRAC));
    localparam logic signed [CW-1:0] K1 =
      CW'(sine_pp_pkg::pp_coef(k, 1, OFF_BITS, SEG_BITS, AMP, FRAC));
    localparam logic signed [CW-1:0] K2 =
      CW'(sine_pp_pkg::pp_coef(k, 2, OFF_BITS, SEG_BITS, AMP, FRAC));
    assign t0[k] = K0;
    assign t1[k] = K1;
    assign t2[k] = K2;
  end

  assign c0 = t0[seg];
  assign c1 = t1[seg];
  assign c2 = t2[seg];
endmodule

// File: rtl/sine_pp_horner.sv
module sine_pp_horner #(
  parameter int XW = 7,
  parameter int CW = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [CW-1:0] c0_in,
  input  logic signed [CW-1:0] c1_in,
  input  logic signed [CW-1:0] c2_in,
  input  logic [XW-1:0]        x_in,
  input  logic                 neg_in,
  output logic                 v_out,
  output logic signed [CW-1:0] y_out,
  output logic                 neg_out
);
  logic signed [CW-1:0] xs_in;
  logic                 a_v;
  logic signed [CW-1:0] a_inner;
  logic signed [CW-1:0] a_c0;
  logic signed [CW-1:0] a_x;
  logic                 a_neg;

  assign xs_in = CW'(x_in);

  // stage A: inner term c1 + x*c2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v     <= 1'b0;
      a_inner <= '0;
      a_c0    <= '0;
      a_x     <= '0;
      a_neg   <= 1'b0;
    end else begin
      a_v     <= v_in;
      a_inner <= c1_in + c2_in * xs_in;
      a_c0    <= c0_in;
      a_x     <= xs_in;
      a_neg   <= neg_in;
    end
  end

  // stage B: c0 + x*inner
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      y_out   <= '0;
      neg_out <= 1'b0;
    end else begin
      v_out   <= a_v;
      y_out   <= a_c0 + a_inner * a_x;
      neg_out <= a_neg;
    end
  end
endmodule

// File: rtl/sine_pp_interp.sv
module sine_pp_interp #(
  parameter int PHASE_W = 12,
  parameter int OUT_W = 16,
  parameter int SEG_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [PHASE_W-1:0]       in_phase,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int OFF_BITS = PHASE_W - 2 - SEG_BITS;
  localparam int XW       = OFF_BITS + 1;
  localparam int FRAC     = 16;
  localparam int CW       = OUT_W + FRAC + 8;
  localparam int AMP      = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [CW-1:0] AMP_W = CW'(AMP);
  localparam logic signed [CW-1:0] HALF  = CW'(longint'(1) << (FRAC - 1));

  function automatic logic signed [CW-1:0] pp_round(input logic signed [CW-1:0] y);
    return (y + HALF) >>> FRAC;
  endfunction

  function automatic logic signed [OUT_W-1:0] pp_clamp_sign(input logic signed [CW-1:0] r,
                                                            input logic neg);
    logic signed [CW-1:0] m;
    if (r > AMP_W)       m = AMP_W;
    else if (r < -AMP_W) m = -AMP_W;
    else                 m = r;
    if (neg) m = -m;
    return m[OUT_W-1:0];
  endfunction

  // fold and table lookup (combinational in front of stage 1)
  logic [SEG_BITS-1:0]  f_seg;
  logic [XW-1:0]        f_x;
  logic                 f_neg;
  logic                 fold_peak;
  logic signed [CW-1:0] r_c0;
  logic signed [CW-1:0] r_c1;
  logic signed [CW-1:0] r_c2;

  sine_pp_fold #(.PHASE_W(PHASE_W), .SEG_BITS(SEG_BITS)) u_fold (
    .phase(in_phase), .seg(f_seg), .xoff(f_x), .negate(f_neg), .at_peak(fold_peak)
  );

  sine_pp_coef_rom #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .AMP(AMP),
                     .FRAC(FRAC), .CW(CW)) u_rom (
    .seg(f_seg), .c0(r_c0), .c1(r_c1), .c2(r_c2)
  );

  // stage 1: register coefficients and offset
  logic                 s1_v;
  logic signed [CW-1:0] s1_c0;
  logic signed [CW-1:0] s1_c1;
  logic signed [CW-1:0] s1_c2;
  logic [XW-1:0]        s1_x;
  logic                 s1_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_c0  <= '0;
      s1_c1  <= '0;
      s1_c2  <= '0;
      s1_x   <= '0;
      s1_neg <= 1'b0;
    end else begin
      s1_v   <= in_valid;
      s1_c0  <= r_c0;
      s1_c1  <= r_c1;
      s1_c2  <= r_c2;
      s1_x   <= f_x;
      s1_neg <= f_neg;
    end
  end

  // stages 2 and 3: Horner evaluation
  logic                 s3_v;
  logic signed [CW-1:0] s3_y;
  logic                 s3_neg;

  sine_pp_horner #(.XW(XW), .CW(CW)) u_horner (
    .clk(clk), .rst_n(rst_n), .v_in(s1_v),
    .c0_in(s1_c0), .c1_in(s1_c1), .c2_in(s1_c2), .x_in(s1_x), .neg_in(s1_neg),
    .v_out(s3_v), .y_out(s3_y), .neg_out(s3_neg)
  );

  // stage 4: round, clamp, apply sign; hold when idle
  logic signed [CW-1:0] s3_rnd;
  logic                 sat_hit;

  assign s3_rnd  = pp_round(s3_y);
  assign sat_hit = s3_v && ((s3_rnd > AMP_W) || (s3_rnd < -AMP_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= s3_v;
      if (s3_v) out_sample <= pp_clamp_sign(s3_rnd, s3_neg);
    end
  end
endmodule

// File: rtl/sine_pp_chk.sv
module sine_pp_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_msb,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample,
  input logic                    sat_hit
);
  localparam logic signed [OUT_W-1:0] RAIL = OUT_W'((1 << (OUT_W - 1)) - 1);

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);

  assert_idle_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##4 !out_valid);

  assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample <= RAIL && out_sample >= -RAIL));

  assert_sat_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> (out_sample == RAIL || out_sample == -RAIL));

  assert_sign_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_msb) |-> ##4 (out_sample >= 0));

  assert_sign_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_msb) |-> ##4 (out_sample <= 0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));
endmodule

bind sine_pp_interp sine_pp_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msb(in_phase[PHASE_W-1]),
  .out_valid(out_valid), .out_sample(out_sample), .sat_hit(sat_hit)
);

// File: tb/tb_sine_pp_interp.sv
module tb_sine_pp_interp;
  localparam int PW   = 12;
  localparam int OW   = 16;
  localparam int NPH  = 1 << PW;
  localparam int AMP  = 32767;
  localparam int LAT  = 4;
  localparam int TOL  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic                 in_valid;
  logic [PW-1:0]        in_phase;
  logic                 out_valid;
  logic signed [OW-1:0] out_sample;

  sine_pp_interp #(.PHASE_W(PW), .OUT_W(OW), .SEG_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  typedef struct { bit v; int p; } ent_t;
  ent_t pipe[$];
  int   got [NPH];
  int   checks = 0;
  int   fails = 0;
  int   last_out = 0;
  bit   done = 1'b0;

  function automatic int ref_sin(int p);
    real r;
    r = real'(AMP) * $sin(2.0 * 3.14159265358979323846 * real'(p) / real'(NPH));
    return int'(r);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: score what is due now, then drive the next input
  task automatic step(bit v, int p);
    ent_t e;
    int   a;
    int   r;
    @(negedge clk);
    e = pipe.pop_front();
    a = int'(out_sample);
    if (e.v) begin
      r = ref_sin(e.p);
      chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
      chk((a - r <= TOL) && (r - a <= TOL), "R2", a, r);
      chk(a <= AMP && a >= -AMP, "R3", a, AMP);
      if (e.p < NPH / 2) chk(a >= 0, "R4", a, 0);
      else               chk(a <= 0, "R4", a, 0);
      got[e.p] = a;
      last_out = a;
    end else begin
      chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
      chk(a == last_out, "R7", a, last_out);
    end
    in_valid = v;
    in_phase = PW'(p);
    pipe.push_back('{v: v, p: p});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] lfsr;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_phase = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    chk(out_sample == 0, "R6", int'(out_sample), 0);
    for (int i = 0; i < LAT; i++) pipe.push_back('{v: 1'b0, p: 0});
    rst_n = 1'b1;

    // a few idle cycles, then every phase back to back (R1, R2)
    for (int i = 0; i < 3; i++) step(1'b0, 0);
    for (int p = 0; p < NPH; p++) step(1'b1, p);

    // interleaved bubbles: R1 spacing and R7 hold
    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], (i * 37 + 11) % NPH);
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 0);

    // R5: exact fold about the quarter point and half-cycle negation
    for (int q = 1; q < NPH / 4; q++)
      chk(got[NPH / 4 + q] == got[NPH / 4 - q], "R5", got[NPH / 4 + q], got[NPH / 4 - q]);
    for (int p = 0; p < NPH / 2; p++)
      chk(got[p + NPH / 2] == -got[p], "R5", got[p + NPH / 2], -got[p]);

    // R8: cardinal phases
    chk(got[0] == 0, "R8", got[0], 0);
    chk(got[NPH / 4] == AMP, "R8", got[NPH / 4], AMP);
    chk(got[NPH / 2] == 0, "R8", got[NPH / 2], 0);
    chk(got[3 * NPH / 4] == -AMP, "R8", got[3 * NPH / 4], -AMP);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule